// File: doc/BRIEF.md
# Register-Driven Memory Access Engine

This block gives software a path to a backing memory through four 64-bit registers: an address, a command, a status and a data word. Software loads the address and, for writes, the data. It then writes a command word that carries a start flag. The engine makes one request on a simple request/acknowledge memory port. When the acknowledge arrives it raises two completion flags in the status word. For block transfers, a command with stepping enabled leaves the command write itself inert. Each later access to the data register then performs one memory transfer and advances the address by one 8-byte word. A data-register write drives a write transfer and a data-register read drives a read transfer.

A lock flag in the command word marks the engine busy. Busy drops by itself once both completion flags are up, as long as stepping is off. A clear flag in the command word zeroes the whole status word. Every error indication in the status word is tied to zero. Register bits are numbered from the most significant end: bit n of a 64-bit word is word[63-n].

Top module: `regmem_engine`

## Requirements
- R1: The register selector picks the address (0), command (1), status (3) and data (4) registers. All are 0 after reset. The address and command registers read back exactly what was last written. Any other selector reads 0.
- R2: A command write with bit 4 (word[59]) set clears the whole status word. The status reads 0 after that write.
- R3: A command write with bit 11 (word[52]) set raises busy, which is status bit 0 (word[63]).
- R4: A command write with start (bit 2, word[61]) set, stepping (bit 19, word[44]) clear and bit 5 (word[58]) clear does one thing. It writes the data register to memory at the address register. Address-done (status bit 2, word[61]) and data-done (status bit 3, word[60]) are set by the acknowledge.
- R5: The same start with bit 5 set reads memory at the address register into the data register and sets both done flags.
- R6: With start and stepping set in the stored command, each data-register write (bit 5 clear) or data-register read (bit 5 set) performs one memory transfer. A stepped read returns the data register as it was before that read's transfer.
- R7: After each stepped transfer, the address register adds 8 within its low 16 bits, wrapping modulo 2^16. The upper 48 bits stay as they were.
- R8: Busy clears once address-done and data-done are both set and the stored command has stepping off. With stepping on, busy stays set until a status clear.
- R9: Writes to the status register have no effect. All status bits other than 0, 2 and 3 read as 0.
- R10: The memory request lasts one cycle. A start that arrives while a transfer is outstanding is ignored and produces no second request.
- R11: A start with address-only (bit 6, word[57]) or data-only (bit 7, word[56]) set issues no memory request and sets no done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_sel | input | 3 | Register selector |
| hst_wdata | input | 64 | Host write data |
| hst_rdata | output | 64 | Host read data (combinational) |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge, at least one cycle after the request |

## Verification
The bound checker watches several rules on every cycle. It checks that the request pulse lasts a single cycle and that no request is issued while a transfer is outstanding. It checks that an acknowledge raises both done flags and that a stepped acknowledge advances only the low 16-bit field by 8. It checks that status clear, lock-to-busy and the busy drop rule take effect one cycle later, and that error bits read as zero. Other behaviour only shows in the bench scenarios. These include the data actually carried to and from memory, a stepped read returning the value from before its own transfer, wrap of the address field across 0xFFF8, and starts that are dropped for being partial or arriving too early.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  localparam int WORD_W = 64;
  localparam int SEL_W  = 3;

  // register bits are numbered from the MSB: bit n lives at word[WORD_W-1-n]
  localparam int CMD_START_B = WORD_W - 1 - 2;
  localparam int CMD_CLR_B   = WORD_W - 1 - 4;
  localparam int CMD_READ_B  = WORD_W - 1 - 5;
  localparam int CMD_AONLY_B = WORD_W - 1 - 6;
  localparam int CMD_DONLY_B = WORD_W - 1 - 7;
  localparam int CMD_LOCK_B  = WORD_W - 1 - 11;
  localparam int CMD_STEP_B  = WORD_W - 1 - 19;

  localparam int STS_BUSY_B  = WORD_W - 1 - 0;
  localparam int STS_ADONE_B = WORD_W - 1 - 2;
  localparam int STS_DDONE_B = WORD_W - 1 - 3;

  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd4;

  typedef struct packed {
    logic start;
    logic clr;
    logic rd;
    logic aonly;
    logic donly;
    logic lock;
    logic step;
  } cmd_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/regmem_rst_sync.sv
module regmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/regmem_cmd_decode.sv
module regmem_cmd_decode
  import regmem_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              fld,
  output logic              xfer_ok
);
  always_comb begin
    fld.start = word[CMD_START_B];
    fld.clr   = word[CMD_CLR_B];
    fld.rd    = word[CMD_READ_B];
    fld.aonly = word[CMD_AONLY_B];
    fld.donly = word[CMD_DONLY_B];
    fld.lock  = word[CMD_LOCK_B];
    fld.step  = word[CMD_STEP_B];
  end

  // a transfer needs both the address and the data phase
  assign xfer_ok = fld.start & ~fld.aonly & ~fld.donly;
endmodule

// File: rtl/regmem_addr_step.sv
module regmem_addr_step #(
  parameter int W        = 64,
  parameter int STEP_W   = 16,
  parameter int STEP_INC = 8
) (
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_out
);
  generate
    if (STEP_W >= W) begin : g_full
      assign addr_out = addr_in + W'(STEP_INC);
    end else begin : g_field
      logic [STEP_W-1:0] low_sum;
      assign low_sum  = addr_in[STEP_W-1:0] + STEP_W'(STEP_INC);
      assign addr_out = {addr_in[W-1:STEP_W], low_sum};
    end
  endgenerate
endmodule

// File: rtl/regmem_seq.sv
module regmem_seq
  import regmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic trig_we,
  input  logic trig_step,
  input  logic mem_ack,
  output logic mem_req,
  output logic idle,
  output logic waiting,
  output logic done,
  output logic op_we,
  output logic op_step
);
  sq_state_e state_q, state_d;
  logic      op_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (trig)    state_d = SQ_REQ;
      SQ_REQ:               state_d = SQ_WAIT;
      SQ_WAIT: if (mem_ack) state_d = SQ_IDLE;
      default:              state_d = SQ_IDLE;
    endcase
  end

  assign op_en = (state_q == SQ_IDLE) & trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_we   <= 1'b0;
      op_step <= 1'b0;
    end else if (op_en) begin
      op_we   <= trig_we;
      op_step <= trig_step;
    end
  end

  assign idle    = (state_q == SQ_IDLE);
  assign mem_req = (state_q == SQ_REQ);
  assign waiting = (state_q == SQ_WAIT);
  assign done    = waiting & mem_ack;
endmodule

// File: rtl/regmem_engine.sv
module regmem_engine
  import regmem_pkg::*;
#(
  parameter int STEP_W   = 16,
  parameter int STEP_INC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [SEL_W-1:0]  hst_sel,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic rst_sync_n;

  logic [WORD_W-1:0] addr_q, addr_d, addr_stepped;
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] data_q, data_d;
  logic              busy_q, busy_d, adone_q, adone_d, ddone_q, ddone_d;
  logic              addr_en, cmd_en, data_en, sts_en;

  cmd_t cur, nxt;
  logic cur_ok, nxt_ok;

  logic wr_addr, wr_cmd, wr_data, rd_data;
  logic trig_cmd, trig_dat, trig, trig_we;
  logic sq_idle, sq_waiting, sq_done, op_we, op_step;

  regmem_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  regmem_cmd_decode cur_dec_i (.word(cmd_q),     .fld(cur), .xfer_ok(cur_ok));
  regmem_cmd_decode nxt_dec_i (.word(hst_wdata), .fld(nxt), .xfer_ok(nxt_ok));

  regmem_addr_step #(.W(WORD_W), .STEP_W(STEP_W), .STEP_INC(STEP_INC)) step_i (
    .addr_in(addr_q), .addr_out(addr_stepped)
  );

  assign wr_addr = hst_wr & (hst_sel == SEL_ADDR);
  assign wr_cmd  = hst_wr & (hst_sel == SEL_CMD);
  assign wr_data = hst_wr & (hst_sel == SEL_DATA);
  assign rd_data = hst_rd & ~hst_wr & (hst_sel == SEL_DATA);

  // command write starts a single transfer; stepped mode waits for data-register traffic
  assign trig_cmd = wr_cmd & nxt_ok & ~nxt.step;
  assign trig_dat = cur_ok & cur.step &
                    ((wr_data & ~cur.rd) | (rd_data & cur.rd));
  assign trig     = sq_idle & (trig_cmd | trig_dat);
  assign trig_we  = trig_cmd ? ~nxt.rd : ~cur.rd;

  regmem_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trig      (trig),
    .trig_we   (trig_we),
    .trig_step (trig_dat),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .idle      (sq_idle),
    .waiting   (sq_waiting),
    .done      (sq_done),
    .op_we     (op_we),
    .op_step   (op_step)
  );

  // address register: host write wins over a step in the same cycle
  always_comb begin
    addr_en = wr_addr | (sq_done & op_step);
    addr_d  = wr_addr ? hst_wdata : addr_stepped;
  end

  // data register: a read completion wins over a host write in the same cycle
  always_comb begin
    data_en = wr_data | (sq_done & ~op_we);
    data_d  = (sq_done & ~op_we) ? mem_rdata : hst_wdata;
  end

  assign cmd_en = wr_cmd;

  always_comb begin
    busy_d  = busy_q;
    adone_d = adone_q;
    ddone_d = ddone_q;
    if (busy_q & adone_q & ddone_q & ~cur.step) busy_d = 1'b0;
    if (sq_done) begin
      adone_d = 1'b1;
      ddone_d = 1'b1;
    end
    if (wr_cmd & nxt.lock) busy_d = 1'b1;
    if (wr_cmd & nxt.clr) begin
      busy_d  = 1'b0;
      adone_d = 1'b0;
      ddone_d = 1'b0;
    end
    sts_en = (busy_d != busy_q) | (adone_d != adone_q) | (ddone_d != ddone_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cmd_q <= '0;
    else if (cmd_en) cmd_q <= hst_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      adone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else if (sts_en) begin
      busy_q  <= busy_d;
      adone_q <= adone_d;
      ddone_q <= ddone_d;
    end
  end

  always_comb begin
    hst_rdata = '0;
    unique case (hst_sel)
      SEL_ADDR: hst_rdata = addr_q;
      SEL_CMD:  hst_rdata = cmd_q;
      SEL_DATA: hst_rdata = data_q;
      SEL_STAT: begin
        hst_rdata[STS_BUSY_B]  = busy_q;
        hst_rdata[STS_ADONE_B] = adone_q;
        hst_rdata[STS_DDONE_B] = ddone_q;
      end
      default:  hst_rdata = '0;
    endcase
  end

  assign mem_we    = op_we;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/regmem_engine_chk.sv
module regmem_engine_chk
  import regmem_pkg::*;
#(
  parameter int STEP_W   = 16,
  parameter int STEP_INC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_wr,
  input logic [SEL_W-1:0]  hst_sel,
  input logic [WORD_W-1:0] hst_wdata,
  input logic [WORD_W-1:0] hst_rdata,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              waiting,
  input logic              op_step,
  input logic [WORD_W-1:0] addr_q,
  input logic              busy_q,
  input logic              adone_q,
  input logic              ddone_q,
  input logic              step_mode
);
  logic cmd_w, clr_w;
  logic [WORD_W-1:0] sts_mask;

  assign cmd_w = hst_wr & (hst_sel == SEL_CMD);
  assign clr_w = cmd_w & hst_wdata[CMD_CLR_B];

  always_comb begin
    sts_mask = '0;
    sts_mask[STS_BUSY_B]  = 1'b1;
    sts_mask[STS_ADONE_B] = 1'b1;
    sts_mask[STS_DDONE_B] = 1'b1;
  end

  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10
  no_req_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mem_req);

  // R2
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (!busy_q && !adone_q && !ddone_q));

  // R3
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && hst_wdata[CMD_LOCK_B] && !hst_wdata[CMD_CLR_B]) |=> busy_q);

  // R4
  done_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_ack && !clr_w) |=> (adone_q && ddone_q));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_ack && op_step && !(hst_wr && hst_sel == SEL_ADDR)) |=>
      ((addr_q[STEP_W-1:0] == $past(addr_q[STEP_W-1:0]) + STEP_W'(STEP_INC)) &&
       (addr_q[WORD_W-1:STEP_W] == $past(addr_q[WORD_W-1:STEP_W]))));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && adone_q && ddone_q && !step_mode && !cmd_w) |=> !busy_q);

  // R9
  error_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel == SEL_STAT) |-> ((hst_rdata & ~sts_mask) == '0));
endmodule

bind regmem_engine regmem_engine_chk #(.STEP_W(STEP_W), .STEP_INC(STEP_INC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hst_wr    (hst_wr),
  .hst_sel   (hst_sel),
  .hst_wdata (hst_wdata),
  .hst_rdata (hst_rdata),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .waiting   (sq_waiting),
  .op_step   (op_step),
  .addr_q    (addr_q),
  .busy_q    (busy_q),
  .adone_q   (adone_q),
  .ddone_q   (ddone_q),
  .step_mode (cur.step)
);

// File: tb/regmem_engine_tb_top.sv
module regmem_engine_tb_top;
  logic        clk;
  logic        rst_n;
  logic        hst_wr, hst_rd;
  logic [2:0]  hst_sel;
  logic [63:0] hst_wdata, hst_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;

  int ncmp = 0;
  int nfail = 0;
  bit finished = 0;

  regmem_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench memory: 32 words indexed by address bits [7:3]
  logic [63:0] mem [32];
  logic [63:0] rd_hold, last_addr;
  int          lat = 2;
  int          cnt = 0;
  int          nreq = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rd_hold;
      end
    end
    if (mem_req) begin
      cnt       <= lat;
      rd_hold   <= mem[mem_addr[7:3]];
      last_addr <= mem_addr;
      nreq      <= nreq + 1;
      if (mem_we) mem[mem_addr[7:3]] <= mem_wdata;
    end
  end

  function automatic logic [63:0] b(input int n);
    return 64'd1 << (63 - n);
  endfunction

  localparam logic [2:0] A_REG = 3'd0, C_REG = 3'd1, S_REG = 3'd3, D_REG = 3'd4;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    hst_sel = sel; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] sel, output logic [63:0] d);
    @(negedge clk);
    hst_sel = sel; hst_rd = 1'b1;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      ncmp++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv, a, d, fnmask, done2;
    int n0;
    rst_n = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0; hst_sel = '0; hst_wdata = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 32; i++) mem[i] = 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_1357);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done2  = b(2) | b(3);
    fnmask = b(2) | b(4) | b(5) | b(6) | b(7) | b(11) | b(19);

    // R1 reset state of every register
    hread(A_REG, rv); check("R1 reset addr", rv, 64'd0);
    hread(C_REG, rv); check("R1 reset cmd", rv, 64'd0);
    hread(S_REG, rv); check("R1 reset status", rv, 64'd0);
    hread(D_REG, rv); check("R1 reset data", rv, 64'd0);

    // R1 read-back and unmapped selectors
    hwrite(A_REG, 64'h0123_4567_89AB_CDEF);
    hread(A_REG, rv); check("R1 addr readback", rv, 64'h0123_4567_89AB_CDEF);
    hwrite(C_REG, 64'hF0E1_D2C3_B4A5_9687 & ~fnmask);
    hread(C_REG, rv); check("R1 cmd readback", rv, 64'hF0E1_D2C3_B4A5_9687 & ~fnmask);
    hread(3'd2, rv); check("R1 unmapped sel 2", rv, 64'd0);
    hread(3'd7, rv); check("R1 unmapped sel 7", rv, 64'd0);

    // R4 single writes, sweeping address and latency
    for (int i = 0; i < 8; i++) begin
      lat = 1 + (i % 3);
      a = 64'h1234_0000_0000_0000 | (64'(i) << 3);
      d = 64'hC0DE_0000_0000_0000 | (64'(i) * 64'h1111);
      hwrite(A_REG, a);
      hwrite(D_REG, d);
      hwrite(C_REG, b(2));
      settle();
      check("R4 memory word written", mem[i], d);
      check("R4 request address", last_addr, a);
      hread(S_REG, rv); check("R4 done flags set", rv, done2);
    end

    // R5 single reads
    for (int i = 8; i < 16; i++) begin
      lat = 1 + (i % 3);
      mem[i] = 64'h5EED_0000_0000_0000 ^ (64'(i) << 20);
      hwrite(C_REG, b(4));
      hwrite(A_REG, 64'(i) << 3);
      hwrite(C_REG, b(2) | b(5));
      settle();
      hread(D_REG, rv); check("R5 data loaded from memory", rv, mem[i]);
      hread(S_REG, rv); check("R5 done flags set", rv, done2);
    end

    // R2 status clear
    hwrite(C_REG, b(4));
    hread(S_REG, rv); check("R2 status cleared", rv, 64'd0);

    // R3 lock raises busy, R8 busy drops after a plain transfer completes
    hwrite(C_REG, b(11));
    hread(S_REG, rv); check("R3 busy after lock", rv, b(0));
    hwrite(C_REG, b(2));
    settle();
    hread(S_REG, rv); check("R8 busy dropped after done", rv, done2);

    // R9 status writes ignored
    hwrite(S_REG, 64'hFFFF_FFFF_FFFF_FFFF);
    hread(S_REG, rv); check("R9 status write ignored", rv, done2);

    // R11 partial starts issue nothing
    hwrite(C_REG, b(4));
    n0 = nreq;
    hwrite(C_REG, b(2) | b(6));
    settle();
    hwrite(C_REG, b(2) | b(7) | b(5));
    settle();
    check("R11 no request for partial start", 64'(nreq), 64'(n0));
    hread(S_REG, rv); check("R11 no done flags", rv, 64'd0);

    // R10 second start during a transfer is dropped
    lat = 3;
    n0 = nreq;
    hwrite(A_REG, 64'h10);
    hwrite(C_REG, b(2) | b(5));
    hwrite(C_REG, b(2) | b(5));
    settle();
    check("R10 one request only", 64'(nreq), 64'(n0 + 1));
    lat = 2;

    // R6/R7 stepped writes across the 16-bit wrap
    hwrite(C_REG, b(4));
    hwrite(A_REG, 64'hDEAD_0000_0000_FFF0);
    hwrite(C_REG, b(2) | b(19) | b(11));
    n0 = nreq;
    settle();
    check("R6 stepped command write starts nothing", 64'(nreq), 64'(n0));
    for (int k = 0; k < 4; k++) begin
      hwrite(D_REG, 64'hBEEF_0000_0000_0000 | 64'(k));
      settle();
    end
    check("R6 stepped write 0", mem[30], 64'hBEEF_0000_0000_0000);
    check("R6 stepped write 1", mem[31], 64'hBEEF_0000_0000_0001);
    check("R6 stepped write 2", mem[0],  64'hBEEF_0000_0000_0002);
    check("R6 stepped write 3", mem[1],  64'hBEEF_0000_0000_0003);
    hread(A_REG, rv); check("R7 address wrapped, upper kept", rv, 64'hDEAD_0000_0000_0010);
    hread(S_REG, rv); check("R8 busy held in stepped mode", rv, b(0) | done2);

    // R6/R7 stepped reads: each read returns the word before its own transfer
    hwrite(C_REG, b(4));
    hwrite(D_REG, 64'h5555_AAAA_5555_AAAA);
    hwrite(A_REG, 64'h0000_0000_0000_0040);
    hwrite(C_REG, b(2) | b(5) | b(19));
    for (int k = 0; k < 5; k++) begin
      hread(D_REG, rv);
      if (k == 0) check("R6 first stepped read is prior data", rv, 64'h5555_AAAA_5555_AAAA);
      else        check("R6 stepped read word", rv, mem[8 + k - 1]);
      settle();
    end
    hread(A_REG, rv); check("R7 address after five reads", rv, 64'h0000_0000_0000_0068);
    hread(S_REG, rv); check("R9 only defined status bits", rv & ~(b(0) | done2), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule